// File: doc/BRIEF.md
# Debug Communications Mailbox Channel

This block passes whole 32-bit words in both directions between an external debugger and the processor under debug. The debugger sees two registers through an addressed register port: a status/identity word and a data word. The processor sees a plain strobe interface with one write strobe, one read strobe, a read data bus and two status outputs. Each direction has its own holding register and its own "word waiting" flag. Either side can poll that flag to learn whether the other side has taken its word.

A processor write fills the processor-to-debugger holder and raises the transmit flag. A debugger read of the data register takes that word and drops the flag. In the other direction, a debugger write of the data register fills the debugger-to-processor holder and raises the receive flag. A processor read strobe drops it. The status word carries a fixed 4-bit implementation version in its top nibble, so software can tell which unit it is talking to. Both sides run on one clock.

Top module: `dbg_mailbox`

## Requirements
- R1: After synchronous reset both flags are 0, `cpu_rdata` is 0, and a debugger read of address 5 returns 0.
- R2: Address 4 reads as the status word. Bits 31:28 hold the parameter `VERSION`, bit 1 is the transmit flag W, bit 0 is the receive flag R, and bits 27:2 read 0.
- R3: A processor write strobe loads `cpu_wdata` into the processor-to-debugger holder and sets W at the next edge. While address 5 is selected, `dbg_rdata` shows that word in the same cycle.
- R4: A debugger read of address 5 clears W at the next edge. A repeated read with no new word returns the same word, leaves W at 0 and counts as no second consumption.
- R5: A debugger write to address 5 loads `dbg_wdata` into the debugger-to-processor holder and sets R at the next edge. The word appears on `cpu_rdata` and R appears on `cpu_rx_full`.
- R6: A processor read strobe clears R at the next edge and leaves `cpu_rdata` unchanged.
- R7: A write into a direction whose flag is already set replaces the held word and leaves the flag set.
- R8: When a load and a consumption of the same direction fall in one cycle, the load wins. The consuming side gets the old word, and the flag stays set with the new word.
- R9: Reading the status word, writing address 4 and accessing any unmapped address change no flag and no held word. Unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sel | input | 1 | Debugger access strobe, one cycle per access |
| dbg_wr | input | 1 | 1 = write, 0 = read, qualified by `dbg_sel` |
| dbg_addr | input | 5 | Debugger register address (4 = status, 5 = data) |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Debugger read data for `dbg_addr`, combinational |
| cpu_wr | input | 1 | Processor write strobe toward the debugger |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rd | input | 1 | Processor read strobe, consumes the received word |
| cpu_rdata | output | 32 | Word held for the processor |
| cpu_rx_full | output | 1 | Receive flag R: a debugger word is waiting |
| cpu_tx_full | output | 1 | Transmit flag W: a processor word is waiting |

## Verification
A flag stuck or cleared by the wrong access shows up on the very next status read or on `cpu_tx_full`/`cpu_rx_full` one edge after the stimulus. A holder loaded from the wrong source, or consumed twice, returns a stale or foreign word on the next data access. The sweeps therefore read the status word back after every load and every consumption. Same-cycle load/consume collisions are driven on purpose to expose the priority between the two.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;

    localparam int WORD_W    = 32;
    localparam int REG_AW    = 5;
    localparam int VER_W     = 4;
    localparam int STAT_ADDR = 4;
    localparam int DATA_ADDR = 5;

    // one-hot view of what a debugger access does this cycle
    typedef struct packed {
        logic stat_hit;
        logic data_take;
        logic data_load;
    } dbg_hit_t;

    function automatic logic [WORD_W-1:0] stat_word(
        input logic [VER_W-1:0] ver,
        input logic             tx_full,
        input logic             rx_full
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1 -: VER_W] = ver;
        w[1] = tx_full;
        w[0] = rx_full;
        return w;
    endfunction

endpackage

// File: rtl/dbgmb_decode.sv
module dbgmb_decode
    import dbgmb_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output dbg_hit_t      hit
);
    localparam logic [AW-1:0] A_STAT = AW'(STAT_ADDR);
    localparam logic [AW-1:0] A_DATA = AW'(DATA_ADDR);

    always_comb begin
        hit.stat_hit  = (addr == A_STAT);
        hit.data_take = sel && !wr && (addr == A_DATA);
        hit.data_load = sel &&  wr && (addr == A_DATA);
    end
endmodule

// File: rtl/dbgmb_slot.sv
module dbgmb_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         take,
    output logic [W-1:0] word,
    output logic         full
);
    // a load beats a take in the same cycle: the new word stays pending
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            full <= 1'b0;
        end else if (load) begin
            word <= load_data;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbgmb_pkg::*;
#(
    parameter int                DW      = WORD_W,
    parameter int                AW      = REG_AW,
    parameter logic [VER_W-1:0]  VERSION = 4'd3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dbg_sel,
    input  logic          dbg_wr,
    input  logic [AW-1:0] dbg_addr,
    input  logic [DW-1:0] dbg_wdata,
    output logic [DW-1:0] dbg_rdata,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_rx_full,
    output logic          cpu_tx_full
);
    localparam logic [AW-1:0] A_DATA = AW'(DATA_ADDR);

    dbg_hit_t          hit;
    logic [DW-1:0]     up_word;   // processor -> debugger
    logic              up_full;
    logic [DW-1:0]     dn_word;   // debugger -> processor
    logic              dn_full;
    logic [WORD_W-1:0] stat;

    dbgmb_decode #(.AW(AW)) u_dec (
        .sel  (dbg_sel),
        .wr   (dbg_wr),
        .addr (dbg_addr),
        .hit  (hit)
    );

    dbgmb_slot #(.W(DW)) u_up (
        .clk       (clk),
        .rst       (rst),
        .load      (cpu_wr),
        .load_data (cpu_wdata),
        .take      (hit.data_take),
        .word      (up_word),
        .full      (up_full)
    );

    dbgmb_slot #(.W(DW)) u_dn (
        .clk       (clk),
        .rst       (rst),
        .load      (hit.data_load),
        .load_data (dbg_wdata),
        .take      (cpu_rd),
        .word      (dn_word),
        .full      (dn_full)
    );

    assign stat = stat_word(VERSION, up_full, dn_full);

    always_comb begin
        if (hit.stat_hit)
            dbg_rdata = DW'(stat);
        else if (dbg_addr == A_DATA)
            dbg_rdata = up_word;
        else
            dbg_rdata = '0;
    end

    assign cpu_rdata   = dn_word;
    assign cpu_rx_full = dn_full;
    assign cpu_tx_full = up_full;
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
    parameter int               DW      = 32,
    parameter int               AW      = 5,
    parameter logic [3:0]       VERSION = 4'd3
) (
    input logic          clk,
    input logic          rst,
    input logic          dbg_sel,
    input logic          dbg_wr,
    input logic [AW-1:0] dbg_addr,
    input logic [DW-1:0] dbg_wdata,
    input logic [DW-1:0] dbg_rdata,
    input logic          cpu_wr,
    input logic          cpu_rd,
    input logic [DW-1:0] cpu_rdata,
    input logic          cpu_rx_full,
    input logic          cpu_tx_full
);
    logic d_take, d_load;
    assign d_take = dbg_sel && !dbg_wr && (dbg_addr == AW'(5));
    assign d_load = dbg_sel &&  dbg_wr && (dbg_addr == AW'(5));

    a_r2_status_layout: assert property (@(posedge clk) disable iff (rst)
        (dbg_addr == AW'(4)) |-> (dbg_rdata[DW-1 -: 4] == VERSION &&
                                  dbg_rdata[1] == cpu_tx_full &&
                                  dbg_rdata[0] == cpu_rx_full));

    a_r3_tx_set: assert property (@(posedge clk) disable iff (rst)
        cpu_wr |=> cpu_tx_full);

    a_r4_consume: assert property (@(posedge clk) disable iff (rst)
        (d_take && !cpu_wr) |=> !cpu_tx_full);

    a_r5_rx_load: assert property (@(posedge clk) disable iff (rst)
        d_load |=> (cpu_rx_full && cpu_rdata == $past(dbg_wdata)));

    a_r6_rx_clear: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !d_load) |=> (!cpu_rx_full && $stable(cpu_rdata)));

    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cpu_wr && !cpu_rd && !d_take && !d_load) |=>
            ($stable(cpu_tx_full) && $stable(cpu_rx_full) && $stable(cpu_rdata)));
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.DW(DW), .AW(AW), .VERSION(VERSION)) u_chk (
    .clk(clk), .rst(rst), .dbg_sel(dbg_sel), .dbg_wr(dbg_wr),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .cpu_rx_full(cpu_rx_full), .cpu_tx_full(cpu_tx_full)
);

// File: tb/dbg_mailbox_test.sv
module dbg_mailbox_test;
    localparam logic [3:0] VER = 4'd3;

    logic        clk = 0;
    logic        rst = 1;
    logic        dbg_sel = 0, dbg_wr = 0;
    logic [4:0]  dbg_addr = 0;
    logic [31:0] dbg_wdata = 0;
    logic [31:0] dbg_rdata;
    logic        cpu_wr = 0, cpu_rd = 0;
    logic [31:0] cpu_wdata = 0;
    logic [31:0] cpu_rdata;
    logic        cpu_rx_full, cpu_tx_full;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dbg_mailbox #(.VERSION(VER)) uut (.*);

    function automatic logic [31:0] stat_exp(input logic w, input logic r);
        return {VER, 26'd0, w, r};
    endfunction

    function automatic logic [31:0] pat(input int i, input int salt);
        return (32'(i) * 32'h9E37_79B9) ^ (32'(salt) << 20) ^ 32'h0F0F_1234;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic dbg_op(input logic wr, input logic [4:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        dbg_sel = 1; dbg_wr = wr; dbg_addr = a; dbg_wdata = d;
        #1 rd = dbg_rdata;
        @(posedge clk); #1;
        dbg_sel = 0; dbg_wr = 0;
    endtask

    task automatic cpu_put(input logic [31:0] d);
        @(negedge clk); cpu_wr = 1; cpu_wdata = d;
        @(posedge clk); #1 cpu_wr = 0;
    endtask

    task automatic cpu_take();
        @(negedge clk); cpu_rd = 1;
        @(posedge clk); #1 cpu_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, a, b;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 / R2 reset state
        dbg_op(0, 5'd4, 0, rd); check("R1/R2 status after reset", rd, stat_exp(0, 0));
        dbg_op(0, 5'd5, 0, rd); check("R1 data after reset", rd, 0);
        check("R1 cpu_rdata after reset", cpu_rdata, 0);
        check("R1 rx flag after reset", {31'd0, cpu_rx_full}, 0);

        // R3 / R4 sweep processor -> debugger
        for (int i = 0; i < 40; i++) begin
            a = pat(i, 1);
            cpu_put(a);
            dbg_op(0, 5'd4, 0, rd); check("R3 W set", rd, stat_exp(1, 0));
            dbg_op(0, 5'd5, 0, rd); check("R3 word seen", rd, a);
            dbg_op(0, 5'd4, 0, rd); check("R4 W cleared", rd, stat_exp(0, 0));
            dbg_op(0, 5'd5, 0, rd); check("R4 reread word", rd, a);
            #2 check("R4 no second consume", {31'd0, cpu_tx_full}, 0);
        end

        // R5 / R6 sweep debugger -> processor
        for (int i = 0; i < 40; i++) begin
            a = pat(i, 2);
            dbg_op(1, 5'd5, a, rd);
            #2 check("R5 word to cpu", cpu_rdata, a);
            check("R5 R flag", {31'd0, cpu_rx_full}, 1);
            dbg_op(0, 5'd4, 0, rd); check("R5 status R", rd, stat_exp(0, 1));
            cpu_take();
            #2 check("R6 R cleared", {31'd0, cpu_rx_full}, 0);
            check("R6 word kept", cpu_rdata, a);
        end

        // R7 overwrite in both directions
        a = pat(7, 3); b = pat(8, 3);
        cpu_put(a); cpu_put(b);
        dbg_op(0, 5'd4, 0, rd); check("R7 W stays", rd, stat_exp(1, 0));
        dbg_op(0, 5'd5, 0, rd); check("R7 newest up word", rd, b);
        dbg_op(1, 5'd5, a, rd); dbg_op(1, 5'd5, b, rd);
        #2 check("R7 newest down word", cpu_rdata, b);
        check("R7 R stays", {31'd0, cpu_rx_full}, 1);
        cpu_take();

        // R8 load and consume in the same cycle, processor -> debugger
        a = pat(9, 4); b = pat(10, 4);
        cpu_put(a);
        @(negedge clk);
        cpu_wr = 1; cpu_wdata = b;
        dbg_sel = 1; dbg_wr = 0; dbg_addr = 5'd5;
        #1 check("R8 consumer gets old word", dbg_rdata, a);
        @(posedge clk); #1 cpu_wr = 0; dbg_sel = 0;
        dbg_op(0, 5'd4, 0, rd); check("R8 W stays set", rd, stat_exp(1, 0));
        dbg_op(0, 5'd5, 0, rd); check("R8 new up word", rd, b);

        // R8 debugger -> processor
        dbg_op(1, 5'd5, a, rd);
        @(negedge clk);
        cpu_rd = 1; dbg_sel = 1; dbg_wr = 1; dbg_addr = 5'd5; dbg_wdata = b;
        #1 check("R8 cpu gets old word", cpu_rdata, a);
        @(posedge clk); #1 cpu_rd = 0; dbg_sel = 0; dbg_wr = 0;
        #2 check("R8 R stays set", {31'd0, cpu_rx_full}, 1);
        check("R8 new down word", cpu_rdata, b);

        // R9 no side effects: W and R both set now
        cpu_put(a);
        dbg_op(0, 5'd4, 0, rd); dbg_op(0, 5'd4, 0, rd);
        check("R9 status read twice", rd, stat_exp(1, 1));
        dbg_op(1, 5'd4, 32'hFFFF_FFFF, rd);
        dbg_op(0, 5'd4, 0, rd); check("R9 status write ignored", rd, stat_exp(1, 1));
        for (int ad = 0; ad < 32; ad++) begin
            if (ad == 4 || ad == 5) continue;
            dbg_op(1, 5'(ad), 32'hDEAD_BEEF, rd);
            dbg_op(0, 5'(ad), 0, rd); check("R9 unmapped read zero", rd, 0);
        end
        #2 check("R9 down word untouched", cpu_rdata, b);
        dbg_op(0, 5'd4, 0, rd); check("R9 flags untouched", rd, stat_exp(1, 1));
        dbg_op(0, 5'd5, 0, rd); check("R9 up word untouched", rd, a);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule